// File: doc/BRIEF.md
# Filtered Branch Record Ring

This block records retired control transfers into a small circular store so that profiling software can read back the most recent branches. Each incoming event carries a source and a target address, a three-bit branch class, a bit saying whether the target runs at the most privileged level, and three status flags: mispredicted, inside a transaction, and transaction abort. A ten-bit select register filters events before they are stored. Its low nine bits work in suppress mode, so a set bit blocks a privilege level or a branch class. Its top bit switches the store from a plain history ring to a return stack.

Accepted records go into a power-of-two ring. A top-of-stack pointer always addresses the newest record. Software programs the block through a small register port: a control register holds enable, freeze-on-interrupt and the frozen status, the select register sets the filter, and a clear register empties the ring. A read index counts back from the newest entry and returns that entry one cycle later. The three status flags are packed into the top bits of the source word, and a sign-extended copy of the address is also given. When freeze-on-interrupt is armed, a performance-monitor interrupt stops recording until software clears the frozen bit.

Top module: `branch_ring`

## Requirements
- R1: After reset the pointer `tos` is 0, `frozen` is 0, recording is disabled, select is 0, and every entry reads back as zero source and zero target.
- R2: An event is considered only while control bit 0 (enable) is 1 and `frozen` is 0. In history mode an accepted event moves `tos` up by one, modulo DEPTH. It is written at the new `tos`, so it reads back as entry 0, and entry i sits at slot (tos - i) mod DEPTH.
- R3: Class codes are 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far branch and 7 unclassified. Select bit (code + 2) suppresses codes 0 to 6. Code 7 is never blocked by a class bit.
- R4: Privilege filtering looks at the target. Select bit 0 suppresses events with `ev_tgt_kernel` = 1, and select bit 1 suppresses events with `ev_tgt_kernel` = 0.
- R5: The stored source word keeps the mispredict flag in bit 63, the in-transaction flag in bit 62, the abort flag in bit 61, and the 61-bit address below them. `rd_src_addr` is that address sign-extended from bit 60, and `rd_mispred`, `rd_in_tx` and `rd_abort` give the three flags.
- R6: After more than DEPTH records the oldest slots are overwritten, and the read index wraps modulo DEPTH.
- R7: A `pmi` pulse sets `frozen` from the next cycle when enable and control bit 1 (freeze arm) are set and call-stack mode is off. An event in the same cycle as the `pmi` is still recorded. Writing control with bit 2 = 0 clears `frozen`, but a `pmi` in the same cycle keeps it set.
- R8: With select bit 9 set (call-stack mode), accepted class 1 and 2 events push a record, accepted class 3 events pop by moving `tos` down by one, and other classes change nothing. In this mode `pmi` never sets `frozen`.
- R9: In call-stack mode a near return that arrives while no pushed entry remains is dropped, and `tos` stays where it is.
- R10: A write to register address 2 makes every entry read as zero and empties the call stack, but leaves `tos` unchanged. An event accepted in the same cycle is still stored and visible.
- R11: Read data appears one cycle after `rd_idx` is applied. If a record is written in the same cycle to the slot being read, the new record is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A retired branch event is present |
| ev_src | input | 61 | Source address |
| ev_dst | input | 64 | Target address |
| ev_class | input | 3 | Branch class code |
| ev_tgt_kernel | input | 1 | Target runs at the most privileged level |
| ev_mispred | input | 1 | Branch was mispredicted |
| ev_in_tx | input | 1 | Branch retired inside a transaction |
| ev_abort | input | 1 | Branch is a transaction abort |
| pmi | input | 1 | Performance-monitor interrupt pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 select, 2 clear |
| reg_wdata | input | 10 | Register write data |
| rd_idx | input | PTR_W | Entry to read, counted back from the newest |
| rd_src_raw | output | 64 | Source word with the flags packed on top |
| rd_src_addr | output | 64 | Sign-extended source address |
| rd_dst | output | 64 | Target address |
| rd_mispred | output | 1 | Mispredict flag of the entry read |
| rd_in_tx | output | 1 | In-transaction flag of the entry read |
| rd_abort | output | 1 | Abort flag of the entry read |
| tos | output | PTR_W | Top-of-stack pointer |
| frozen | output | 1 | Recording is halted by an interrupt |

## Verification
A few functions can land in the same clock edge, and the bench drives each pair together in one cycle. An interrupt can arrive in the same edge as a branch event, or in the same edge as the software write that clears the freeze. The bench then checks that the event was still stored and that `frozen` stayed set. A record can also be written to the slot being read, or be accepted in the same cycle as a clear. Here the bench expects the new record in the read data, and expects the cleared slots around it to read as zero.

// File: rtl/branch_ring_pkg.sv
package branch_ring_pkg;
  typedef enum logic [2:0] {
    BC_COND  = 3'd0,
    BC_RCALL = 3'd1,
    BC_ICALL = 3'd2,
    BC_NRET  = 3'd3,
    BC_IJMP  = 3'd4,
    BC_RJMP  = 3'd5,
    BC_FAR   = 3'd6,
    BC_OTHER = 3'd7
  } br_class_e;

  localparam int NCLS       = 7;
  localparam int SEL_W      = 10;
  localparam int SEL_KERN   = 0;
  localparam int SEL_USER   = 1;
  localparam int SEL_CLASS0 = 2;
  localparam int SEL_CS     = 9;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_SEL  = 2'd1;
  localparam logic [1:0] REG_CLR  = 2'd2;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_ARM = 1;
  localparam int CTRL_FRZ = 2;

  localparam int NFLAG = 3;
endpackage

// File: rtl/branch_ring_filter.sv
module branch_ring_filter
  import branch_ring_pkg::*;
(
  input  logic             ev_valid,
  input  logic [2:0]       ev_class,
  input  logic             ev_tgt_kernel,
  input  logic [SEL_W-1:0] sel,
  input  logic             rec_on,
  input  logic             stack_nonempty,
  output logic             push,
  output logic             pop
);
  logic [NCLS-1:0] class_hit;
  logic priv_sup, accept, cs_mode, is_call, is_ret;

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    assign class_hit[g] = (ev_class == 3'(g)) & sel[SEL_CLASS0 + g];
  end

  always_comb begin
    priv_sup = ev_tgt_kernel ? sel[SEL_KERN] : sel[SEL_USER];
    accept   = ev_valid & rec_on & ~priv_sup & ~(|class_hit);
    cs_mode  = sel[SEL_CS];
    is_call  = (ev_class == BC_RCALL) || (ev_class == BC_ICALL);
    is_ret   = (ev_class == BC_NRET);
    push     = accept & (cs_mode ? is_call : 1'b1);
    pop      = accept & cs_mode & is_ret & stack_nonempty;
  end
endmodule

// File: rtl/branch_ring_tos.sv
module branch_ring_tos #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             clear,
  output logic [PTR_W-1:0] tos,
  output logic [PTR_W-1:0] wr_addr,
  output logic             nonempty
);
  logic [PTR_W-1:0] tos_q;
  logic [CNT_W-1:0] cnt_q, cnt_base;

  assign cnt_base = clear ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q <= '0;
      cnt_q <= '0;
    end else begin
      if (push)     tos_q <= PTR_W'(tos_q + 1'b1);
      else if (pop) tos_q <= PTR_W'(tos_q - 1'b1);
      if (push)
        cnt_q <= (cnt_base == CNT_W'(DEPTH)) ? cnt_base : CNT_W'(cnt_base + 1'b1);
      else if (pop && !clear)
        cnt_q <= CNT_W'(cnt_q - 1'b1);
      else
        cnt_q <= cnt_base;
    end
  end

  assign tos      = tos_q;
  assign wr_addr  = PTR_W'(tos_q + 1'b1);
  assign nonempty = (cnt_q != '0);

  AST_PUSH_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    push |=> tos_q == PTR_W'($past(tos_q) + 1'b1)); // R2
  AST_POP_RETREATS: assert property (@(posedge clk) disable iff (rst)
    pop |=> tos_q == PTR_W'($past(tos_q) - 1'b1)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> $stable(tos_q)); // R10
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt_q != '0); // R9
endmodule

// File: rtl/branch_ring_store.sv
module branch_ring_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 128,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q, byp_d;
  logic [DEPTH-1:0]  valid_q;
  logic              byp_q, vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    mem_q <= mem[rd_addr];
    byp_d <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      byp_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      if (clear) valid_q <= '0;
      if (wr_en) valid_q[wr_addr] <= 1'b1;
      byp_q <= wr_en && (wr_addr == rd_addr);
      if (wr_en && (wr_addr == rd_addr)) vld_q <= 1'b1;
      else if (clear)                    vld_q <= 1'b0;
      else                               vld_q <= valid_q[rd_addr];
    end
  end

  assign rd_data = !vld_q ? '0 : (byp_q ? byp_d : mem_q);

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clear && !wr_en) |=> rd_data == '0); // R10
endmodule

// File: rtl/branch_ring.sv
module branch_ring
  import branch_ring_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SLOT_W = 64,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int ADDR_W = SLOT_W - NFLAG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_src,
  input  logic [SLOT_W-1:0] ev_dst,
  input  logic [2:0]        ev_class,
  input  logic              ev_tgt_kernel,
  input  logic              ev_mispred,
  input  logic              ev_in_tx,
  input  logic              ev_abort,
  input  logic              pmi,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [SEL_W-1:0]  reg_wdata,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [SLOT_W-1:0] rd_src_raw,
  output logic [SLOT_W-1:0] rd_src_addr,
  output logic [SLOT_W-1:0] rd_dst,
  output logic              rd_mispred,
  output logic              rd_in_tx,
  output logic              rd_abort,
  output logic [PTR_W-1:0]  tos,
  output logic              frozen
);
  localparam int DATA_W = 2 * SLOT_W;

  if (!(DEPTH == 4 || DEPTH == 8 || DEPTH == 16 || DEPTH == 32)) begin : g_bad_depth
    $error("branch_ring: DEPTH must be 4, 8, 16 or 32");
  end

  logic             enable_q, arm_q, frozen_q;
  logic [SEL_W-1:0] sel_q;
  logic             push, pop, clear, nonempty, rec_on;
  logic [PTR_W-1:0] tos_w, wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  assign clear  = reg_wr && (reg_addr == REG_CLR);
  assign rec_on = enable_q & ~frozen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0;
      arm_q    <= 1'b0;
      frozen_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      if (reg_wr && reg_addr == REG_CTRL) begin
        enable_q <= reg_wdata[CTRL_EN];
        arm_q    <= reg_wdata[CTRL_ARM];
      end
      if (reg_wr && reg_addr == REG_SEL) sel_q <= reg_wdata;
      if (pmi && enable_q && arm_q && !sel_q[SEL_CS])
        frozen_q <= 1'b1;
      else if (reg_wr && reg_addr == REG_CTRL && !reg_wdata[CTRL_FRZ])
        frozen_q <= 1'b0;
    end
  end

  branch_ring_filter u_filter (
    .ev_valid       (ev_valid),
    .ev_class       (ev_class),
    .ev_tgt_kernel  (ev_tgt_kernel),
    .sel            (sel_q),
    .rec_on         (rec_on),
    .stack_nonempty (nonempty),
    .push           (push),
    .pop            (pop)
  );

  branch_ring_tos #(.DEPTH(DEPTH)) u_tos (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (pop),
    .clear    (clear),
    .tos      (tos_w),
    .wr_addr  (wr_addr),
    .nonempty (nonempty)
  );

  assign wr_data = {ev_mispred, ev_in_tx, ev_abort, ev_src, ev_dst};
  assign rd_addr = PTR_W'(tos_w - rd_idx);

  branch_ring_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .wr_en   (push),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign rd_src_raw  = rd_data[DATA_W-1:SLOT_W];
  assign rd_dst      = rd_data[SLOT_W-1:0];
  assign rd_src_addr = {{NFLAG{rd_src_raw[ADDR_W-1]}}, rd_src_raw[ADDR_W-1:0]};
  assign rd_mispred  = rd_src_raw[SLOT_W-1];
  assign rd_in_tx    = rd_src_raw[SLOT_W-2];
  assign rd_abort    = rd_src_raw[SLOT_W-3];
  assign tos         = tos_w;
  assign frozen      = frozen_q;

  AST_FROZEN_HALTS: assert property (@(posedge clk) disable iff (rst)
    frozen_q |-> !(push || pop)); // R7
  AST_CS_NO_FREEZE: assert property (@(posedge clk) disable iff (rst)
    $rose(frozen_q) |-> !$past(sel_q[SEL_CS])); // R8
  AST_TGT_PRIV: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_tgt_kernel && sel_q[SEL_KERN]) |-> !(push || pop)); // R4
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enable_q |-> !(push || pop)); // R2
endmodule

// File: tb/branch_ring_bench.sv
module branch_ring_bench;
  localparam int DEPTH = 8;
  localparam int PW    = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic [60:0] ev_src = '0;
  logic [63:0] ev_dst = '0;
  logic [2:0]  ev_class = '0;
  logic        ev_tgt_kernel = 1'b0, ev_mispred = 1'b0, ev_in_tx = 1'b0, ev_abort = 1'b0;
  logic        pmi = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [9:0]  reg_wdata = '0;
  logic [PW-1:0] rd_idx = '0;
  logic [63:0] rd_src_raw, rd_src_addr, rd_dst;
  logic        rd_mispred, rd_in_tx, rd_abort, frozen;
  logic [PW-1:0] tos;

  int n_chk = 0;
  int n_fail = 0;

  branch_ring #(.DEPTH(DEPTH)) u_branch_ring (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_src(ev_src), .ev_dst(ev_dst),
    .ev_class(ev_class), .ev_tgt_kernel(ev_tgt_kernel), .ev_mispred(ev_mispred),
    .ev_in_tx(ev_in_tx), .ev_abort(ev_abort), .pmi(pmi), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_idx(rd_idx),
    .rd_src_raw(rd_src_raw), .rd_src_addr(rd_src_addr), .rd_dst(rd_dst),
    .rd_mispred(rd_mispred), .rd_in_tx(rd_in_tx), .rd_abort(rd_abort),
    .tos(tos), .frozen(frozen)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_ev(input logic [2:0] c, input logic k, input logic [60:0] s,
                          input logic [63:0] d, input logic m = 0, input logic t = 0,
                          input logic a = 0);
    ev_valid = 1'b1; ev_class = c; ev_tgt_kernel = k; ev_src = s; ev_dst = d;
    ev_mispred = m; ev_in_tx = t; ev_abort = a;
  endtask

  task automatic send(input logic [2:0] c, input logic k, input logic [60:0] s,
                      input logic [63:0] d, input logic m = 0, input logic t = 0,
                      input logic a = 0);
    @(negedge clk);
    drive_ev(c, k, s, d, m, t, a);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int i);
    @(negedge clk);
    rd_idx = PW'(i);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 tos after reset", 64'(tos), 0);
    chk("R1 frozen after reset", 64'(frozen), 0);
    rd(0); chk("R1 entry0 dst", rd_dst, 0); chk("R1 entry0 src", rd_src_raw, 0);
    rd(5); chk("R1 entry5 dst", rd_dst, 0);
    send(3'd5, 1'b0, 61'h10, 64'h20);
    chk("R2 disabled ignores event", 64'(tos), 0);
  endtask

  task automatic t_basic();
    wreg(2'd0, 10'h001);
    send(3'd5, 1'b0, 61'h1000, 64'h2000);
    send(3'd0, 1'b0, 61'h1100, 64'h2100);
    send(3'd6, 1'b1, 61'h1FFF_FFFF_8000_1000, 64'h3000, 1'b1, 1'b0, 1'b1);
    chk("R2 tos after three", 64'(tos), 3);
    rd(0);
    chk("R2 entry0 dst", rd_dst, 64'h3000);
    chk("R5 raw source packing", rd_src_raw, 64'hBFFF_FFFF_8000_1000);
    chk("R5 sign-extended source", rd_src_addr, 64'hFFFF_FFFF_8000_1000);
    chk("R5 flags m/t/a", {61'd0, rd_mispred, rd_in_tx, rd_abort}, 64'b101);
    rd(1); chk("R2 entry1 dst", rd_dst, 64'h2100);
    rd(2); chk("R2 entry2 dst", rd_dst, 64'h2000);
    chk("R5 positive source", rd_src_addr, 64'h1000);
  endtask

  task automatic t_filter();
    wreg(2'd1, 10'h004);
    send(3'd0, 1'b0, 61'h4000, 64'h4000);
    chk("R3 conditional suppressed", 64'(tos), 3);
    send(3'd5, 1'b0, 61'h4100, 64'h4100);
    chk("R3 relative jump kept", 64'(tos), 4);
    wreg(2'd1, 10'h001);
    send(3'd5, 1'b1, 61'h4200, 64'h4200);
    chk("R4 kernel target suppressed", 64'(tos), 4);
    send(3'd5, 1'b0, 61'h4300, 64'h4300);
    chk("R4 user target kept", 64'(tos), 5);
    rd(0); chk("R4 entry0 dst", rd_dst, 64'h4300);
    wreg(2'd1, 10'h002);
    send(3'd1, 1'b0, 61'h4350, 64'h4350);
    chk("R4 user target suppressed", 64'(tos), 5);
    wreg(2'd1, 10'h1FC);
    send(3'd7, 1'b1, 61'h4400, 64'h4400);
    chk("R3 unclassified kept", 64'(tos), 6);
    send(3'd2, 1'b1, 61'h4500, 64'h4500);
    chk("R3 indirect call suppressed", 64'(tos), 6);
    wreg(2'd1, 10'h000);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 10; k++) send(3'd5, 1'b0, 61'(64'h5000 + k), 64'h6000 + 64'(k));
    chk("R6 tos wrapped", 64'(tos), 0);
    rd(0); chk("R6 newest after wrap", rd_dst, 64'h6009);
    rd(7); chk("R6 oldest surviving", rd_dst, 64'h6002);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    rd_idx = 3'd7;
    drive_ev(3'd5, 1'b0, 61'h7000, 64'h7000);
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R11 same-slot write returned", rd_dst, 64'h7000);
    chk("R11 tos", 64'(tos), 1);
    rd(7); chk("R11 read latency path", rd_dst, 64'h6003);
  endtask

  task automatic t_clear();
    wreg(2'd2, 10'h000);
    chk("R10 clear keeps tos", 64'(tos), 1);
    rd(0); chk("R10 entry0 cleared", rd_dst, 0);
    rd(3); chk("R10 entry3 cleared", rd_dst, 0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = '0;
    drive_ev(3'd5, 1'b0, 61'h7100, 64'h7100);
    @(negedge clk);
    reg_wr = 1'b0; ev_valid = 1'b0;
    chk("R10 tos after clear+event", 64'(tos), 2);
    rd(0); chk("R10 event with clear kept", rd_dst, 64'h7100);
    rd(1); chk("R10 neighbour cleared", rd_dst, 0);
  endtask

  task automatic t_freeze();
    wreg(2'd0, 10'h003);
    @(negedge clk);
    pmi = 1'b1;
    drive_ev(3'd5, 1'b0, 61'h8000, 64'h8000);
    @(negedge clk);
    pmi = 1'b0; ev_valid = 1'b0;
    chk("R7 event in pmi cycle recorded", 64'(tos), 3);
    chk("R7 frozen set", 64'(frozen), 1);
    send(3'd5, 1'b0, 61'h8100, 64'h8100);
    chk("R7 frozen blocks record", 64'(tos), 3);
    @(negedge clk);
    pmi = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 10'h003;
    @(negedge clk);
    pmi = 1'b0; reg_wr = 1'b0;
    chk("R7 pmi beats clear", 64'(frozen), 1);
    wreg(2'd0, 10'h003);
    chk("R7 freeze cleared", 64'(frozen), 0);
    send(3'd5, 1'b0, 61'h8200, 64'h8200);
    chk("R7 recording resumes", 64'(tos), 4);
  endtask

  task automatic t_callstack();
    wreg(2'd2, 10'h000);
    wreg(2'd1, 10'h200);
    send(3'd3, 1'b0, 61'h9050, 64'h9050);
    chk("R9 return on empty dropped", 64'(tos), 4);
    send(3'd1, 1'b0, 61'h9000, 64'h9000);
    send(3'd2, 1'b0, 61'h9100, 64'h9100);
    chk("R8 two calls pushed", 64'(tos), 6);
    rd(0); chk("R8 top is last call", rd_dst, 64'h9100);
    send(3'd5, 1'b0, 61'h9200, 64'h9200);
    chk("R8 jump ignored", 64'(tos), 6);
    send(3'd3, 1'b0, 61'h9300, 64'h9300);
    chk("R8 return pops", 64'(tos), 5);
    rd(0); chk("R8 top after pop", rd_dst, 64'h9000);
    @(negedge clk); pmi = 1'b1;
    @(negedge clk); pmi = 1'b0;
    chk("R8 no freeze in call-stack mode", 64'(frozen), 0);
    send(3'd3, 1'b0, 61'h9400, 64'h9400);
    chk("R8 second pop", 64'(tos), 4);
    send(3'd3, 1'b0, 61'h9500, 64'h9500);
    chk("R9 underflow return dropped", 64'(tos), 4);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_filter();
    t_wrap();
    t_bypass();
    t_clear();
    t_freeze();
    t_callstack();
    finish_run();
  end
endmodule